// File: doc/BRIEF.md
# Shared Buffer Load-Lock Arbiter

Several DMA channel threads move data through one shared staging buffer. To keep any one thread from filling the buffer while others are stuck, only one thread at a time may issue loads into it. This block keeps that single load-lock token. The lock is not requested or returned through handshakes. A thread takes it by issuing a load while nobody else holds it. It gives the lock up by issuing any instruction that ends its load phase: a store of any kind, a barrier, a wait, a normal end or an abort.

Every cycle, each channel drives a 4-bit event code that gives the class of the instruction it is executing, or idle. A channel stalled at a load keeps presenting the load code until it is granted. In the same cycle as a load, the block answers with a per-channel grant or stall. The owner index and a valid flag come from registers. When the lock is free, or freed in the current cycle, and several channels load, a round-robin pointer that starts after the last owner chooses the winner.

Top module: `lla_lock_arbiter`

## Requirements
- R1: After reset the lock is free (`owner_vld_o` = 0). With all events idle, no grant or stall is asserted.
- R2: Event codes are: 0 idle, 1 load, 2 peripheral load, 3 store, 4 peripheral store, 5 zero-fill store, 6 read barrier, 7 write barrier, 8 wait-for-peripheral, 9 wait-for-event, 10 normal end, 11 abort. Codes 0 and 12 to 15 have no effect on the lock.
- R3: A load (code 1 or 2) on a free lock is granted in the same cycle. From the next cycle, `owner_o` holds that channel and `owner_vld_o` is 1.
- R4: A load from a non-owner while the owner is not releasing is not granted. Its stall bit is asserted in the same cycle and the owner is unchanged.
- R5: A load from the owner is always granted at once, and the lock stays with it across consecutive loads.
- R6: A store from the owner (code 3, 4 or 5) frees the lock from the next cycle.
- R7: A read or write barrier from the owner (code 6 or 7) frees the lock.
- R8: A wait-for-peripheral or wait-for-event from the owner (code 8 or 9) frees the lock.
- R9: A normal end or an abort from the owner (code 10 or 11) frees the lock.
- R10: Release codes from a channel that does not own the lock leave the owner unchanged.
- R11: When the owner releases in a cycle where another channel loads, that load is granted in the same cycle and the loader owns the lock next cycle.
- R12: When several channels load on a free or freeing lock, the grant goes to the first loading channel at or after (last owner + 1) modulo N, in cyclic order. After reset the last owner is taken as N-1.
- R13: At most one grant is asserted per cycle. A channel's stall bit is 1 exactly when it presents a load and is not granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_i | input | NCH*4 | Per-channel event codes, channel i in bits [4i+3:4i] |
| grant_o | output | NCH | Load granted this cycle, one bit per channel |
| stall_o | output | NCH | Load refused this cycle, channel must hold its load |
| owner_o | output | IDW | Index of the current lock owner |
| owner_vld_o | output | 1 | Lock is held by `owner_o` |

## Verification
A behavioural model predicts grant, stall and owner on every cycle. The directed sequences take each release class by itself from the owner, and then the same classes from non-owners, which separates a real release from a change in the owner register caused by any channel. Release and claim in the same cycle, and four-way contention with the last owner at different positions, show whether the priority rotates from the previous owner rather than from a fixed channel. A long stretch of random codes weighted toward loads then mixes holding, stalling and freeing in arbitrary orders.

// File: rtl/lla_pkg.sv
package lla_pkg;
  localparam int EV_W = 4;

  typedef enum logic [EV_W-1:0] {
    EV_IDLE       = 4'd0,
    EV_LOAD       = 4'd1,
    EV_LOAD_PER   = 4'd2,
    EV_STORE      = 4'd3,
    EV_STORE_PER  = 4'd4,
    EV_STORE_ZERO = 4'd5,
    EV_BAR_RD     = 4'd6,
    EV_BAR_WR     = 4'd7,
    EV_WAIT_PER   = 4'd8,
    EV_WAIT_EVT   = 4'd9,
    EV_FINISH     = 4'd10,
    EV_ABORT      = 4'd11
  } lock_ev_e;
endpackage

// File: rtl/lla_classify.sv
module lla_classify
  import lla_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic [NCH*EV_W-1:0] ev_i,
  output logic [NCH-1:0]      ld_o,
  output logic [NCH-1:0]      rel_o
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [EV_W-1:0] code;
    assign code = ev_i[i*EV_W +: EV_W];
    // R2: load classes
    assign ld_o[i]  = (code == EV_LOAD) || (code == EV_LOAD_PER);
    // R6 R7 R8 R9: every class that ends a load phase
    assign rel_o[i] = (code >= EV_STORE) && (code <= EV_ABORT);
  end
endmodule

// File: rtl/lla_rr_pick.sv
module lla_rr_pick #(
  parameter int NCH = 4,
  parameter int IDW = 2
) (
  input  logic [NCH-1:0] req_i,
  input  logic [IDW-1:0] last_i,
  output logic           pick_vld_o,
  output logic [IDW-1:0] pick_id_o
);
  always_comb begin
    int c;
    pick_vld_o = 1'b0;
    pick_id_o  = '0;
    for (int k = 1; k <= NCH; k++) begin
      c = int'(last_i) + k;
      if (c >= NCH) c = c - NCH;
      if (!pick_vld_o && req_i[c]) begin
        pick_vld_o = 1'b1;
        pick_id_o  = IDW'(c);
      end
    end
  end

  // R12: the chosen channel must be one that asked
  always_comb begin
    if (pick_vld_o) begin
      a_r12_pick_requested: assert (req_i[pick_id_o]);
    end
  end
endmodule

// File: rtl/lla_lock_arbiter.sv
module lla_lock_arbiter
  import lla_pkg::*;
#(
  parameter int NCH = 4,
  localparam int IDW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NCH*EV_W-1:0] ev_i,
  output logic [NCH-1:0]      grant_o,
  output logic [NCH-1:0]      stall_o,
  output logic [IDW-1:0]      owner_o,
  output logic                owner_vld_o
);
  logic [NCH-1:0] ld, rel;
  logic [IDW-1:0] own_q, last_q;
  logic           vld_q;
  logic           own_ld, own_rel, avail;
  logic           pick_vld;
  logic [IDW-1:0] pick_id;

  lla_classify #(.NCH(NCH)) i_cls (
    .ev_i  (ev_i),
    .ld_o  (ld),
    .rel_o (rel)
  );

  assign own_ld  = vld_q && ld[own_q];
  assign own_rel = vld_q && rel[own_q];
  // R11: a lock released this cycle can be claimed this cycle
  assign avail   = !vld_q || own_rel;

  lla_rr_pick #(.NCH(NCH), .IDW(IDW)) i_pick (
    .req_i      (ld & {NCH{avail}}),
    .last_i     (last_q),
    .pick_vld_o (pick_vld),
    .pick_id_o  (pick_id)
  );

  always_comb begin
    grant_o = '0;
    if (own_ld)        grant_o[own_q]   = 1'b1;
    else if (pick_vld) grant_o[pick_id] = 1'b1;
  end

  assign stall_o = ld & ~grant_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      own_q  <= '0;
      last_q <= IDW'(NCH - 1);
    end else if (pick_vld) begin
      vld_q  <= 1'b1;
      own_q  <= pick_id;
      last_q <= pick_id;
    end else if (own_rel) begin
      vld_q  <= 1'b0;
    end
  end

  assign owner_o     = own_q;
  assign owner_vld_o = vld_q;

  a_r13_one_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_o));
  a_r13_stall_only_on_load: assert property (@(posedge clk) disable iff (rst)
    (stall_o & ~ld) == '0);
  a_r3_grant_takes_lock: assert property (@(posedge clk) disable iff (rst)
    (|grant_o) |=> owner_vld_o);
  a_r5_owner_keeps_lock: assert property (@(posedge clk) disable iff (rst)
    (owner_vld_o && grant_o[owner_o]) |=> (owner_vld_o && owner_o == $past(owner_o)));
  a_r10_hold_without_release: assert property (@(posedge clk) disable iff (rst)
    (owner_vld_o && !own_rel) |=> (owner_vld_o && $stable(owner_o)));
  a_r6_release_frees: assert property (@(posedge clk) disable iff (rst)
    (own_rel && grant_o == '0) |=> !owner_vld_o);
  a_r4_busy_refuses_others: assert property (@(posedge clk) disable iff (rst)
    (owner_vld_o && !own_rel) |-> ((grant_o & ~ld) == '0 && (grant_o == '0 || grant_o[owner_o])));
endmodule

// File: tb/test_lla_lock_arbiter.sv
`timescale 1ns/1ps
module test_lla_lock_arbiter;
  localparam int NCH = 4;
  localparam int IDW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH*4-1:0] ev = '0;
  logic [NCH-1:0] grant, stall;
  logic [IDW-1:0] owner;
  logic owner_vld;

  int checks = 0;
  int errors = 0;
  int m_owner = -1;
  int m_last = NCH - 1;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lla_lock_arbiter #(.NCH(NCH)) i_lla_lock_arbiter (
    .clk(clk), .rst(rst), .ev_i(ev),
    .grant_o(grant), .stall_o(stall), .owner_o(owner), .owner_vld_o(owner_vld)
  );

  function automatic bit is_ld(int c);
    return c == 1 || c == 2;
  endfunction
  function automatic bit is_rel(int c);
    return c inside {[3:11]};
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // one cycle: drive codes after the falling edge, compare, then advance model
  task automatic cyc(string tag, int c0, int c1, int c2, int c3);
    int codes[NCH];
    int winner;
    bit freeing;
    logic [NCH-1:0] eg, es;
    codes = '{c0, c1, c2, c3};
    @(negedge clk);
    for (int i = 0; i < NCH; i++) ev[i*4 +: 4] = 4'(codes[i]);
    #1;
    winner = -1;
    freeing = (m_owner >= 0) && is_rel(codes[m_owner]);
    if (m_owner >= 0 && is_ld(codes[m_owner])) winner = m_owner;
    else if (m_owner < 0 || freeing) begin
      for (int k = 1; k <= NCH; k++) begin
        int c = (m_last + k) % NCH;
        if (winner < 0 && is_ld(codes[c])) winner = c;
      end
    end
    eg = '0;
    if (winner >= 0) eg[winner] = 1'b1;
    for (int i = 0; i < NCH; i++) es[i] = is_ld(codes[i]) && (i != winner);
    chk(tag, "grant", int'(grant), int'(eg));
    chk(tag, "stall", int'(stall), int'(es));
    chk(tag, "owner_vld", int'(owner_vld), int'(m_owner >= 0));
    if (m_owner >= 0) chk(tag, "owner", int'(owner), m_owner);
    @(posedge clk);
    if (winner >= 0) begin
      if (winner != m_owner) m_last = winner;
      m_owner = winner;
    end else if (freeing) m_owner = -1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    cyc("R1", 0, 0, 0, 0);
    cyc("R3", 0, 0, 1, 0);         // ch2 claims
    cyc("R5", 0, 0, 2, 0);         // owner loads again
    cyc("R4", 0, 1, 1, 0);         // ch1 stalls, ch2 granted
    cyc("R4", 0, 1, 0, 2);         // ch1, ch3 stall
    cyc("R10", 3, 6, 0, 11);       // non-owner releases ignored
    cyc("R2", 12, 13, 14, 15);     // unused codes
    cyc("R2", 0, 0, 15, 0);        // unused code from owner
    cyc("R6", 0, 0, 3, 0);         // store frees
    cyc("R1", 0, 0, 0, 0);
    cyc("R3", 2, 0, 0, 0);         // ch0 claims via peripheral load
    cyc("R11", 4, 0, 0, 1);        // release and claim same cycle
    cyc("R6", 0, 0, 0, 5);         // zero-fill store frees
    cyc("R12", 1, 1, 1, 1);        // last=3 -> ch0
    cyc("R7", 6, 1, 1, 1);         // read barrier, ch1 next
    cyc("R7", 1, 7, 1, 1);         // write barrier, ch2 next
    cyc("R8", 1, 1, 8, 1);         // wait-periph, ch3 next
    cyc("R8", 1, 1, 1, 9);         // wait-event, ch0 next
    cyc("R9", 10, 0, 0, 0);        // normal end frees
    cyc("R12", 0, 1, 0, 1);        // last=0 -> ch1
    cyc("R9", 0, 11, 0, 0);        // abort frees
    cyc("R12", 1, 0, 1, 0);        // last=1 -> ch2
    cyc("R10", 10, 11, 0, 9);      // non-owner releases
    cyc("R6", 1, 0, 4, 1);         // peripheral store, ch3 wins after ch2
    cyc("R9", 0, 0, 0, 11);
    for (int n = 0; n < 3000; n++) begin
      int c[NCH];
      for (int i = 0; i < NCH; i++) begin
        int r = int'($urandom_range(0, 9));
        c[i] = (r < 5) ? int'($urandom_range(1, 2)) : int'($urandom_range(0, 15));
      end
      cyc("R13", c[0], c[1], c[2], c[3]);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule